// File: doc/BRIEF.md
# Three-Wire Serial Register Port with Burst Transfers

This block is the slave side of a three-wire serial link made of a chip enable, a serial clock and a data line. The data line is split into an input, an output and an output enable. Each session starts with a command byte. The command byte picks one of two banks, an index within that bank, and a direction. The block then writes or returns one byte, or a whole bank in burst order.

The clock bank has three kinds of entries. Indices 0 to 6 are eight-bit timekeeping registers. Index 7 holds a write-lock flag. Index 8 holds the charger configuration byte, whose bits are stored but not interpreted. The scratch bank is 31 bytes.

All the serial pins are brought into the system clock domain through synchronisers. The shifting, command decoding and burst sequencing run on the system clock. A clock-bank burst write is collected in a shadow buffer. It is applied in one step when the session ends, and only if it was complete.

Top module: `triwire_regif`

## Requirements
- R1: Bits move least significant first and are sampled on rising serial clock edges. In the command byte, bit 7 must be 1, bit 6 selects the bank (1 = scratch, 0 = clock), bits 5:1 give the index, and bit 0 set means read.
- R2: Read data is presented on the falling serial clock edges that follow the command byte, least significant bit first. The output enable is low out of reset and is high only while read data is being presented.
- R3: A command byte whose bit 7 is 0 causes nothing: no storage changes and no output is enabled, until chip enable goes low.
- R4: Chip enable going low aborts the session. The output enable drops, and the bit counter restarts, so the next session decodes its command correctly.
- R5: Clock-bank indices 0 to 6 and 8 store and return all eight bits. Index 7 stores only bit 7 and returns 0 in bits 6:0.
- R6: A read from clock-bank index 31 (command 0xBF) returns clock indices 0 through 7 in ascending order.
- R7: A write to clock-bank index 31 (command 0xBE) changes indices 0 to 7 only if exactly eight whole data bytes arrive before chip enable drops. With seven or nine bytes, nothing changes.
- R8: Scratch-bank index 31 (0xFE write, 0xFF read) transfers scratch bytes 0 through 30 in ascending order. A write burst that stops early keeps the bytes already received.
- R9: While bit 7 of clock index 7 is 1, every write to the scratch bank and every write to a clock index other than 7 is ignored. A write to index 7 still takes effect.
- R10: A single scratch-bank write (0xC0 | index<<1) followed by a read (the same value with bit 0 set) returns the stored byte.
- R11: After the single byte of a non-burst read, the next falling edge releases the data line (output enable low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling and all state |
| rstN | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip enable; high frames a session |
| sclk | input | 1 | Serial clock from the master |
| sdIn | input | 1 | Serial data from the master |
| sdOut | output | 1 | Serial data to the master |
| sdOe | output | 1 | High when sdOut drives the shared data line |

## Verification
The assertions assume that each serial clock level, and each chip enable level, lasts for several system clock cycles. This lets every edge pass the synchronisers as exactly one rise or fall event. They also assume that chip enable changes only while the serial clock is low. The stimulus holds every serial clock phase for six system cycles. It changes data only while the clock is low, and it raises or drops chip enable only with the serial clock already low. The write-lock and shadow-commit properties rely on the strobes that the control section produces under those conditions.

// File: rtl/triwire_pkg.sv
package triwire_pkg;
  localparam int RAM_DEPTH   = 31;
  localparam int CLK_REGS    = 8;
  localparam int TIME_REGS   = CLK_REGS - 1;
  localparam int CTRL_IDX    = CLK_REGS - 1;
  localparam int CHG_IDX     = CLK_REGS;
  localparam int BURST_IDX   = 31;
  localparam int IDX_W       = 5;
  localparam int SH_W        = $clog2(CLK_REGS);

  typedef struct packed {
    logic              regWe;
    logic [3:0]        regIdx;
    logic              ramWe;
    logic [IDX_W-1:0]  ramIdx;
    logic              shWe;
    logic [SH_W-1:0]   shIdx;
    logic [7:0]        wdata;
    logic              commit;
  } dpStrobeT;
endpackage

// File: rtl/triwire_datapath.sv
module triwire_datapath
  import triwire_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         stb,
  input  logic             rdBank,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [7:0]       rdData,
  output logic             wp
);
  logic [7:0] timeRegs [TIME_REGS];
  logic [7:0] chgReg;
  logic [7:0] ram      [RAM_DEPTH];
  logic [7:0] shadow   [CLK_REGS];

  for (genvar g = 0; g < TIME_REGS; g++) begin : g_time
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) timeRegs[g] <= '0;
      else if (stb.commit && !wp) timeRegs[g] <= shadow[g];
      else if (stb.regWe && stb.regIdx == 4'(g)) timeRegs[g] <= stb.wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wp     <= 1'b0;
      chgReg <= '0;
    end else begin
      if (stb.commit) wp <= shadow[CTRL_IDX][7];
      else if (stb.regWe && stb.regIdx == 4'(CTRL_IDX)) wp <= stb.wdata[7];
      if (stb.regWe && stb.regIdx == 4'(CHG_IDX)) chgReg <= stb.wdata;
    end
  end

  for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_ram
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ram[g] <= '0;
      else if (stb.ramWe && stb.ramIdx == IDX_W'(g)) ram[g] <= stb.wdata;
    end
  end

  for (genvar g = 0; g < CLK_REGS; g++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shadow[g] <= '0;
      else if (stb.shWe && stb.shIdx == SH_W'(g)) shadow[g] <= stb.wdata;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdBank) begin
      if (int'(rdIdx) < RAM_DEPTH) rdData = ram[rdIdx];
    end else if (int'(rdIdx) < TIME_REGS) begin
      rdData = timeRegs[rdIdx[SH_W-1:0]];
    end else if (int'(rdIdx) == CTRL_IDX) begin
      rdData = {wp, 7'b0};
    end else if (int'(rdIdx) == CHG_IDX) begin
      rdData = chgReg;
    end
  end

  p_lock_clock_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWe && wp) |-> (stb.regIdx == 4'(CTRL_IDX)));
  p_lock_ram_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWe |-> !wp);
  p_ram_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.ramWe |-> (int'(stb.ramIdx) < RAM_DEPTH));
endmodule

// File: rtl/triwire_ctrl.sv
module triwire_ctrl
  import triwire_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce,
  input  logic             sclk,
  input  logic             sdIn,
  input  logic             wp,
  input  logic [7:0]       rdData,
  output logic             rdBank,
  output logic [IDX_W-1:0] rdIdx,
  output dpStrobeT         stb,
  output logic             sdOut,
  output logic             sdOe
);
  typedef enum logic [1:0] {ST_CMD, ST_IGNORE, ST_WR, ST_RD} stateT;

  logic [SYNC_STAGES-1:0] ceSync, sclkSync, sdSync;
  logic ceS, sclkS, sdS, sclkPrev, cePrev;
  logic rise, fall, ceFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSync   <= '0;
      sclkSync <= '0;
      sdSync   <= '0;
      sclkPrev <= 1'b0;
      cePrev   <= 1'b0;
    end else begin
      ceSync   <= {ceSync[SYNC_STAGES-2:0], ce};
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      sdSync   <= {sdSync[SYNC_STAGES-2:0], sdIn};
      sclkPrev <= sclkS;
      cePrev   <= ceS;
    end
  end

  assign ceS    = ceSync[SYNC_STAGES-1];
  assign sclkS  = sclkSync[SYNC_STAGES-1];
  assign sdS    = sdSync[SYNC_STAGES-1];
  assign rise   = ceS && sclkS && !sclkPrev;
  assign fall   = ceS && !sclkS && sclkPrev;
  assign ceFall = cePrev && !ceS;

  stateT            state;
  logic [2:0]       bitCnt, outCnt;
  logic [7:0]       shiftIn, rdShift;
  logic             bank, burst, rdActive;
  logic [IDX_W-1:0] addr;
  logic [5:0]       byteIdx;
  logic [3:0]       shCount;
  logic [7:0]       inByte;
  logic             byteDone;
  logic [IDX_W-1:0] cmdAddr;
  logic [5:0]       rdLimit;

  assign inByte   = {sdS, shiftIn[7:1]};
  assign byteDone = rise && (bitCnt == 3'd7);
  assign cmdAddr  = inByte[5:1];
  assign rdLimit  = bank ? 6'(RAM_DEPTH) : 6'(CLK_REGS);

  always_comb begin
    if (state == ST_CMD) begin
      rdBank = inByte[6];
      rdIdx  = (int'(cmdAddr) == BURST_IDX) ? '0 : cmdAddr;
    end else begin
      rdBank = bank;
      rdIdx  = IDX_W'(byteIdx + 6'd1);
    end
  end

  always_comb begin
    stb       = '0;
    stb.wdata = inByte;
    if (state == ST_WR && byteDone) begin
      if (!bank) begin
        if (burst) begin
          if (int'(byteIdx) < CLK_REGS) begin
            stb.shWe  = 1'b1;
            stb.shIdx = byteIdx[SH_W-1:0];
          end
        end else if (byteIdx == 6'd0 && int'(addr) <= CHG_IDX &&
                     (!wp || int'(addr) == CTRL_IDX)) begin
          stb.regWe  = 1'b1;
          stb.regIdx = addr[3:0];
        end
      end else if (!wp) begin
        if (burst) begin
          if (int'(byteIdx) < RAM_DEPTH) begin
            stb.ramWe  = 1'b1;
            stb.ramIdx = byteIdx[IDX_W-1:0];
          end
        end else if (byteIdx == 6'd0 && int'(addr) < RAM_DEPTH) begin
          stb.ramWe  = 1'b1;
          stb.ramIdx = addr;
        end
      end
    end
    stb.commit = ceFall && state == ST_WR && !bank && burst &&
                 int'(byteIdx) == CLK_REGS && bitCnt == 3'd0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      outCnt   <= '0;
      shiftIn  <= '0;
      rdShift  <= '0;
      bank     <= 1'b0;
      burst    <= 1'b0;
      addr     <= '0;
      byteIdx  <= '0;
      rdActive <= 1'b0;
      sdOut    <= 1'b0;
      sdOe     <= 1'b0;
      shCount  <= '0;
    end else if (!ceS) begin
      state    <= ST_CMD;
      bitCnt   <= '0;
      outCnt   <= '0;
      byteIdx  <= '0;
      rdActive <= 1'b0;
      sdOe     <= 1'b0;
      shCount  <= '0;
    end else begin
      if (stb.shWe) shCount <= shCount + 4'd1;
      if (rise) begin
        shiftIn <= inByte;
        bitCnt  <= bitCnt + 3'd1;
        if (byteDone) begin
          case (state)
            ST_CMD: begin
              if (!inByte[7]) begin
                state <= ST_IGNORE;
              end else begin
                bank    <= inByte[6];
                addr    <= cmdAddr;
                burst   <= (int'(cmdAddr) == BURST_IDX);
                byteIdx <= '0;
                if (inByte[0]) begin
                  state    <= ST_RD;
                  rdShift  <= rdData;
                  outCnt   <= '0;
                  rdActive <= 1'b1;
                end else begin
                  state <= ST_WR;
                end
              end
            end
            ST_WR: if (byteIdx != 6'h3F) byteIdx <= byteIdx + 6'd1;
            default: ;
          endcase
        end
      end
      if (fall && state == ST_RD) begin
        if (rdActive) begin
          sdOut  <= rdShift[0];
          sdOe   <= 1'b1;
          outCnt <= outCnt + 3'd1;
          if (outCnt == 3'd7) begin
            if (burst && (byteIdx + 6'd1) < rdLimit) begin
              rdShift <= rdData;
              byteIdx <= byteIdx + 6'd1;
            end else begin
              rdActive <= 1'b0;
            end
          end else begin
            rdShift <= rdShift >> 1;
          end
        end else begin
          sdOe <= 1'b0;
        end
      end
    end
  end

  p_oe_in_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    sdOe |-> (state == ST_RD));
  p_ce_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ceS |=> !sdOe);
  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> (!stb.regWe && !stb.ramWe && !stb.shWe && !sdOe));
  p_commit_exact_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (int'(shCount) == CLK_REGS));
endmodule

// File: rtl/triwire_regif.sv
module triwire_regif
  import triwire_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic clk,
  input  logic rstN,
  input  logic ce,
  input  logic sclk,
  input  logic sdIn,
  output logic sdOut,
  output logic sdOe
);
  dpStrobeT         stb;
  logic             rdBank;
  logic [IDX_W-1:0] rdIdx;
  logic [7:0]       rdData;
  logic             wp;

  triwire_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ce(ce), .sclk(sclk), .sdIn(sdIn),
    .wp(wp), .rdData(rdData), .rdBank(rdBank), .rdIdx(rdIdx),
    .stb(stb), .sdOut(sdOut), .sdOe(sdOe)
  );

  triwire_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdBank(rdBank), .rdIdx(rdIdx),
    .rdData(rdData), .wp(wp)
  );
endmodule

// File: tb/triwire_regif_test.sv
module triwire_regif_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, sdIn = 1'b0;
  logic sdOut, sdOe;
  int   nRun = 0, nFail = 0;

  typedef struct { logic [7:0] v; string tag; } expT;
  expT        expQ[$];
  logic [7:0] gotQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  triwire_regif uut (.clk(clk), .rstN(rstN), .ce(ce), .sclk(sclk),
                     .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (gotQ.size() != 0 && expQ.size() != 0) begin
      expT e;
      logic [7:0] g;
      e = expQ.pop_front();
      g = gotQ.pop_front();
      chk(e.tag, g, e.v);
    end
  end

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic ceHigh();
    sclk = 1'b0; ce = 1'b1; waitHalf();
  endtask

  task automatic ceLow();
    sclk = 1'b0; waitHalf(); ce = 1'b0;
    repeat (4) waitHalf();
  endtask

  task automatic sendByte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdIn = b[i]; waitHalf();
      sclk = 1'b1; waitHalf();
    end
  endtask

  task automatic recvBits(int n, output logic [7:0] b, output logic oeSeen);
    b = '0; oeSeen = 1'b0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; waitHalf();
      b[i] = sdOut; oeSeen = oeSeen | sdOe;
      sclk = 1'b1; waitHalf();
    end
  endtask

  task automatic expectByte(logic [7:0] v, string tag);
    expT e;
    e.v = v; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic recvByte();
    logic [7:0] b;
    logic oe;
    recvBits(8, b, oe);
    gotQ.push_back(b);
  endtask

  task automatic writeOne(logic [7:0] cmd, logic [7:0] d);
    ceHigh(); sendByte(cmd); sendByte(d); ceLow();
  endtask

  task automatic readOne(logic [7:0] cmd, logic [7:0] exp, string tag);
    expectByte(exp, tag);
    ceHigh(); sendByte(cmd); recvByte(); ceLow();
  endtask

  task automatic burstWriteClock(int n, logic [7:0] base);
    ceHigh(); sendByte(8'hBE);
    for (int i = 0; i < n; i++) sendByte(base + 8'(i));
    ceLow();
  endtask

  task automatic burstReadClock(logic [7:0] base, string tag);
    ceHigh(); sendByte(8'hBF);
    for (int i = 0; i < 8; i++) begin
      expectByte((i == 7) ? 8'h00 : base + 8'(i), tag);
      recvByte();
    end
    ceLow();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic oe;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 reset oe", {7'b0, sdOe}, 8'h00);

    // R1 R5 single clock-bank accesses
    writeOne(8'h84, 8'h5A);
    readOne(8'h85, 8'h5A, "R1 R5 reg2");
    writeOne(8'h90, 8'hA7);
    readOne(8'h91, 8'hA7, "R5 charger");
    writeOne(8'h8E, 8'h7F);
    readOne(8'h8F, 8'h00, "R5 control low bits");

    // R3 bad command ignored
    writeOne(8'h04, 8'h33);
    readOne(8'h85, 8'h5A, "R3 write ignored");
    ceHigh(); sendByte(8'h05); recvBits(8, b, oe); ceLow();
    chk("R3 no output", {7'b0, oe}, 8'h00);

    // R4 abort
    ceHigh(); sendByte(8'h86); sendByte(8'hFF);
    sclk = 1'b0; sdIn = 1'b1; waitHalf(); sclk = 1'b1; waitHalf();
    ceLow();
    writeOne(8'h86, 8'hC3);
    readOne(8'h87, 8'hC3, "R4 restart");
    ceHigh(); sendByte(8'h85); recvBits(3, b, oe);
    chk("R2 oe during read", {7'b0, oe}, 8'h01);
    ceLow();
    chk("R4 oe after drop", {7'b0, sdOe}, 8'h00);

    // R11 release after single byte
    ceHigh(); sendByte(8'h85); recvByte();
    expectByte(8'h5A, "R11 byte");
    sclk = 1'b0; waitHalf();
    chk("R11 released", {7'b0, sdOe}, 8'h00);
    ceLow();

    // R6 R7 clock burst
    burstWriteClock(8, 8'h10);
    burstReadClock(8'h10, "R6 R7 exact eight");
    burstWriteClock(7, 8'h20);
    burstReadClock(8'h10, "R7 seven discarded");
    burstWriteClock(9, 8'h30);
    burstReadClock(8'h10, "R7 nine discarded");
    readOne(8'h91, 8'hA7, "R6 charger untouched");

    // R8 scratch burst
    ceHigh(); sendByte(8'hFE);
    for (int i = 0; i < 31; i++) sendByte(8'(i * 3 + 1));
    ceLow();
    ceHigh(); sendByte(8'hFF);
    for (int i = 0; i < 31; i++) begin
      expectByte(8'(i * 3 + 1), "R8 burst");
      recvByte();
    end
    ceLow();
    ceHigh(); sendByte(8'hFE);
    for (int i = 0; i < 5; i++) sendByte(8'hE0 + 8'(i));
    ceLow();
    readOne(8'hC9, 8'hE4, "R8 R10 early stop kept");
    readOne(8'hCB, 8'h10, "R8 R10 rest intact");
    writeOne(8'hD4, 8'h6B);
    readOne(8'hD5, 8'h6B, "R10 single scratch");

    // R9 write lock
    writeOne(8'h8E, 8'h80);
    writeOne(8'h80, 8'h99);
    writeOne(8'hC0, 8'h99);
    readOne(8'h81, 8'h10, "R9 clock locked");
    readOne(8'hC1, 8'hE0, "R9 scratch locked");
    readOne(8'h8F, 8'h80, "R9 control set");
    writeOne(8'h8E, 8'h00);
    writeOne(8'h80, 8'h99);
    readOne(8'h81, 8'h99, "R9 unlocked");

    repeat (20) @(negedge clk);
    chk("queue drained", 8'(expQ.size() + gotQ.size()), 8'h00);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule